// File: doc/BRIEF.md
# Interrupting GPIO Port Controller

A register-mapped general-purpose I/O port for a small set of pins (twelve by default). Software drives each pin through an output-value register and a direction register, and reads the pin levels back through a synchronizer. Each pin also feeds its own event detector. The detector can be set to catch a rising edge, a falling edge, either edge, a high level or a low level. A detected event latches into a sticky status bit when that pin is enabled. Software clears a status bit by writing a one to it.

Status bits pass through a mask to reach a single active-high interrupt line. Masking and unmasking use two separate write-one registers, so one pin can change without a read-modify-write. A software reset register holds the whole port at its defaults for as long as its bit 0 is 1.

The bus side uses word addresses with single-cycle write and read strobes. Read data is registered and is valid on the cycle after the read strobe.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset: every mask bit is 1, the enable, status, output, direction and mode registers are 0, `pin_oe` and `pin_out` are 0, and `irq` is 0.
- R2: Word 6 holds the output values and word 8 the direction bits (1 = drive). Both read back. `pin_out` and `pin_oe` show a written value on the cycle after the write.
- R3: Word 7 returns the pin levels after a two-flop synchronizer. A level held for three or more cycles is returned unchanged.
- R4: Each pin's mode is a 3-bit field at bit 4*p. Pins 0..7 use word 9, and pins 8..11 use word 10 with p = pin - 8. Codes: 0 falling edge, 1 rising edge, 2 low level, 3 high level, 4 either edge. Codes 5, 6 and 7 never raise status. The bits between fields read as 0.
- R5: A pin's status bit can be set only while its enable bit in word 0 is 1.
- R6: Writing 1 to a bit of word 3 clears that status bit, and writing 0 leaves it unchanged. A level mode sets the bit again while the level persists. Status reads from word 1.
- R7: Writing 1 to a bit of word 4 masks that pin. Writing 1 to a bit of word 5 unmasks it. Zero bits in either write leave the mask unchanged. Both words read back the current mask.
- R8: Word 2 reads status AND NOT mask. `irq` goes to 1 one cycle after any bit of that value is 1, and returns to 0 one cycle after all bits are 0.
- R9: Bit 0 of word 15 is the software reset, and it reads back. While it is 1, every other register returns to its R1 value and writes to those registers are ignored. Writing 0 releases it.
- R10: Bits at and above the pin count read as 0 and are not stored. Words 11 to 14 read as 0.
- R11: Writes to words 1, 2 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; `rd_data` is valid on the next cycle |
| addr | input | 4 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pin_in | input | 12 | Pin levels, asynchronous |
| pin_out | output | 12 | Output values to the pads |
| pin_oe | output | 12 | Per-pin output enable |
| irq | output | 1 | Active-high interrupt request |

## Verification
The checker assumes that the write and read strobes are never high together and that `addr` is stable during a strobe. It also assumes that `pin_in` changes by at most one transition per pin within a few cycles, so that each edge passes through the synchronizer separately. The stimulus drives every strobe for exactly one cycle between falling clock edges. It changes `pin_in` only on a falling edge and then waits at least five cycles before it reads status or sends the next transition.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Word addresses of the register file
  localparam logic [3:0] A_ENABLE = 4'd0;
  localparam logic [3:0] A_STATUS = 4'd1;
  localparam logic [3:0] A_SHOW   = 4'd2;
  localparam logic [3:0] A_CLEAR  = 4'd3;
  localparam logic [3:0] A_MSET   = 4'd4;
  localparam logic [3:0] A_MCLR   = 4'd5;
  localparam logic [3:0] A_DOUT   = 4'd6;
  localparam logic [3:0] A_DIN    = 4'd7;
  localparam logic [3:0] A_DIR    = 4'd8;
  localparam logic [3:0] A_MODE0  = 4'd9;
  localparam logic [3:0] A_MODE1  = 4'd10;
  localparam logic [3:0] A_SWRST  = 4'd15;

  // Detector mode codes; other codes disable detection
  typedef enum logic [2:0] {
    MD_FALL = 3'd0,
    MD_RISE = 3'd1,
    MD_LOW  = 3'd2,
    MD_HIGH = 3'd3,
    MD_BOTH = 3'd4
  } det_mode_e;

  localparam int MODE_W      = 3;
  localparam int MODE_STRIDE = 4;
  localparam int PINS_PER_MW = 8;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              smp,
  input  logic [MODE_W-1:0] mode,
  output logic              hit
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= smp;
  end

  always_comb begin
    case (mode)
      MD_FALL: hit = prev_q & ~smp;
      MD_RISE: hit = ~prev_q & smp;
      MD_LOW:  hit = ~smp;
      MD_HIGH: hit = smp;
      MD_BOTH: hit = prev_q ^ smp;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 12,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic              irq
);
  localparam int                PAD_W    = DATA_W - N_PINS;
  localparam logic [N_PINS-1:0] ALL_ONES = {N_PINS{1'b1}};

  logic              swrst_q;
  logic              core_rst;
  logic [N_PINS-1:0] en_q, mask_q, stat_q, out_q, dir_q;
  logic [MODE_W-1:0] mode_q [N_PINS];
  logic [N_PINS-1:0] smp, hit, clr_bits;
  logic [N_PINS-1:0] wlow;
  logic              irq_q;
  logic [DATA_W-1:0] mode_rd0, mode_rd1, rd_mux;
  logic              unused_wdata;

  assign core_rst     = rst | swrst_q;
  assign wlow         = wr_data[N_PINS-1:0];
  assign unused_wdata = ^wr_data;

  function automatic logic wr_at(input logic [3:0] a);
    return wr_en && (addr == a);
  endfunction

  function automatic logic [DATA_W-1:0] ext(input logic [N_PINS-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  // Software reset bit: only the pin reset clears it
  always_ff @(posedge clk) begin
    if (rst)                swrst_q <= 1'b0;
    else if (wr_at(A_SWRST)) swrst_q <= wr_data[0];
  end

  gpio_sync #(.W(N_PINS)) u_sync (
    .clk     (clk),
    .rst     (core_rst),
    .d_async (pin_in),
    .d_sync  (smp)
  );

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    gpio_pin_detect u_det (
      .clk  (clk),
      .rst  (core_rst),
      .smp  (smp[p]),
      .mode (mode_q[p]),
      .hit  (hit[p])
    );
  end

  // Configuration registers
  always_ff @(posedge clk) begin
    if (core_rst) begin
      en_q   <= '0;
      mask_q <= ALL_ONES;
      out_q  <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_at(A_ENABLE)) en_q  <= wlow;
      if (wr_at(A_DOUT))   out_q <= wlow;
      if (wr_at(A_DIR))    dir_q <= wlow;
      if (wr_at(A_MSET))
        mask_q <= mask_q | wlow;
      else if (wr_at(A_MCLR))
        mask_q <= mask_q & ~wlow;
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < N_PINS; p++) begin
      if (core_rst)
        mode_q[p] <= '0;
      else if ((p < PINS_PER_MW) ? wr_at(A_MODE0) : wr_at(A_MODE1))
        mode_q[p] <= wr_data[MODE_STRIDE*(p % PINS_PER_MW) +: MODE_W];
    end
  end

  // Sticky status: a new event wins over a clear in the same cycle
  assign clr_bits = wr_at(A_CLEAR) ? wlow : '0;

  always_ff @(posedge clk) begin
    if (core_rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_bits) | (hit & en_q);
      irq_q  <= |(stat_q & ~mask_q);
    end
  end

  // Mode readback images
  always_comb begin
    mode_rd0 = '0;
    mode_rd1 = '0;
    for (int p = 0; p < N_PINS; p++) begin
      if (p < PINS_PER_MW)
        mode_rd0[MODE_STRIDE*(p % PINS_PER_MW) +: MODE_W] = mode_q[p];
      else
        mode_rd1[MODE_STRIDE*(p % PINS_PER_MW) +: MODE_W] = mode_q[p];
    end
  end

  always_comb begin
    case (addr)
      A_ENABLE: rd_mux = ext(en_q);
      A_STATUS: rd_mux = ext(stat_q);
      A_SHOW:   rd_mux = ext(stat_q & ~mask_q);
      A_MSET,
      A_MCLR:   rd_mux = ext(mask_q);
      A_DOUT:   rd_mux = ext(out_q);
      A_DIN:    rd_mux = ext(smp);
      A_DIR:    rd_mux = ext(dir_q);
      A_MODE0:  rd_mux = mode_rd0;
      A_MODE1:  rd_mux = mode_rd1;
      A_SWRST:  rd_mux = {{(DATA_W-1){1'b0}}, swrst_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = irq_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 12,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [N_PINS-1:0] pin_oe,
  input logic              irq,
  input logic              swrst_q,
  input logic [N_PINS-1:0] en_q,
  input logic [N_PINS-1:0] mask_q,
  input logic [N_PINS-1:0] stat_q
);
  // R1
  reset_defaults_chk: assert property (@(posedge clk)
    $past(rst) |-> (mask_q == {N_PINS{1'b1}} && en_q == '0 && stat_q == '0 && !irq));

  // R2
  dir_to_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_DIR && !swrst_q) |=> (pin_oe == $past(wr_data[N_PINS-1:0])));

  // R5
  enable_gates_status_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));

  // R7
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_MSET) |=>
      ((mask_q & $past(wr_data[N_PINS-1:0])) == $past(wr_data[N_PINS-1:0])));

  // R7
  mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_MCLR && !swrst_q) |=> ((mask_q & $past(wr_data[N_PINS-1:0])) == '0));

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst || swrst_q)
    (|(stat_q & ~mask_q)) |=> irq);

  // R8
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(stat_q & ~mask_q)) |=> !irq);

  // R9
  swrst_holds_chk: assert property (@(posedge clk) disable iff (rst)
    swrst_q |=> (en_q == '0 && stat_q == '0 && mask_q == {N_PINS{1'b1}}));

  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[DATA_W-1:N_PINS] == '0 || addr == A_MODE0 || addr == A_MODE1 || $past(addr) == A_MODE0 || $past(addr) == A_MODE1));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .N_PINS (N_PINS),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .addr    (addr),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .pin_oe  (pin_oe),
  .irq     (irq),
  .swrst_q (swrst_q),
  .en_q    (en_q),
  .mask_q  (mask_q),
  .stat_q  (stat_q)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  localparam int N = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [3:0]    addr = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe;
  logic          irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic rd_seen = 1'b0;
  logic done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  gpio_irq_ctrl #(.N_PINS(N)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: read data is valid on the falling edge after the sampling edge
  always @(posedge clk) begin
    rd_seen <= rd_en;
    cycles  <= cycles + 1;
  end

  always @(negedge clk) begin
    if (rd_seen) begin
      item_t it;
      if (sb_q.size() == 0) begin
        chk("scoreboard underflow", 32'd1, 32'd0);
      end else begin
        it = sb_q.pop_front();
        chk(it.tag, rd_data, it.exp);
      end
    end
    if (!done && cycles > 100000) begin
      chk("watchdog", 32'd1, 32'd0);
      done = 1'b1;
      finish_run();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 pin_oe", {20'd0, pin_oe}, 32'd0);
    chk("R1 pin_out", {20'd0, pin_out}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(4'd4, 32'hFFF, "R1 mask");
    rd(4'd0, 32'h0, "R1 enable");
    rd(4'd1, 32'h0, "R1 status");
    rd(4'd8, 32'h0, "R1 direction");
    rd(4'd9, 32'h0, "R1 mode0");

    // R2 output and direction
    wr(4'd6, 32'hA5C);
    wr(4'd8, 32'h0F0);
    chk("R2 pin_out", {20'd0, pin_out}, 32'hA5C);
    chk("R2 pin_oe", {20'd0, pin_oe}, 32'h0F0);
    rd(4'd6, 32'hA5C, "R2 dout readback");
    rd(4'd8, 32'h0F0, "R2 dir readback");

    // R10 upper bits and reserved words
    wr(4'd6, 32'hFFFF_FFFF);
    rd(4'd6, 32'hFFF, "R10 dout upper bits");
    rd(4'd11, 32'h0, "R10 reserved 11");
    rd(4'd14, 32'h0, "R10 reserved 14");

    // R11 writes to read-only words
    wr(4'd7, 32'h123);
    wr(4'd1, 32'hFFF);
    wr(4'd2, 32'hFFF);
    rd(4'd7, 32'h0, "R11 din unaffected");
    rd(4'd1, 32'h0, "R11 status unaffected");

    // R3 synchronized input
    pin_in = 12'h5A3;
    idle(3);
    rd(4'd7, 32'h5A3, "R3 din");
    pin_in = 12'h000;
    idle(4);

    // R4 mode fields (bits between fields dropped)
    wr(4'd9, 32'h8854_3218);
    wr(4'd10, 32'h0000_4001);
    rd(4'd9, 32'h0054_3210, "R4 mode0 fields");
    rd(4'd10, 32'h0000_4001, "R4 mode1 fields");

    // R5 nothing without enable (pin2 low-level is pending)
    idle(4);
    rd(4'd1, 32'h0, "R5 disabled pins");
    wr(4'd0, 32'h93B);
    idle(4);
    rd(4'd1, 32'h0, "R5 pin2 not enabled");

    // R4 rising / high / both
    pin_in = 12'h11A;
    idle(5);
    rd(4'd1, 32'h11A, "R4 rise/high/both status");
    chk("R8 irq masked", {31'd0, irq}, 32'd0);
    rd(4'd2, 32'h0, "R8 show masked");

    // R7 / R8 unmask pin1
    wr(4'd5, 32'h002);
    idle(2);
    chk("R8 irq raised", {31'd0, irq}, 32'd1);
    rd(4'd2, 32'h002, "R8 show unmasked");
    rd(4'd4, 32'hFFD, "R7 mask after clear");
    wr(4'd5, 32'h000);
    rd(4'd5, 32'hFFD, "R7 zero write no effect");

    // R6 clear, level re-asserts
    wr(4'd3, 32'h00A);
    idle(2);
    rd(4'd1, 32'h118, "R6 clear with level reassert");
    chk("R8 irq dropped", {31'd0, irq}, 32'd0);

    // R4 falls: pin4 both sets, pin1 rise and pin8 rise do not
    pin_in = 12'h008;
    idle(5);
    wr(4'd3, 32'hFFF);
    idle(2);
    rd(4'd1, 32'h008, "R6 clear all, high level stays");
    pin_in = 12'h809;
    idle(5);
    rd(4'd1, 32'h808, "R4 pin11 both rise, pin0 fall-mode no rise");
    pin_in = 12'h008;
    idle(5);
    rd(4'd1, 32'h809, "R4 pin0 falling edge");
    // R4 disabled code on pin5
    pin_in = 12'h028;
    idle(5);
    pin_in = 12'h008;
    idle(5);
    rd(4'd1, 32'h809, "R4 code5 no detection");

    // R5 enabling pin2 low level
    wr(4'd0, 32'h93F);
    idle(2);
    rd(4'd1, 32'h80D, "R5 pin2 after enable");

    // R7 set and clear
    wr(4'd4, 32'h002);
    rd(4'd4, 32'hFFF, "R7 mask set");
    wr(4'd5, 32'h004);
    idle(2);
    chk("R8 irq pin2", {31'd0, irq}, 32'd1);
    rd(4'd2, 32'h004, "R8 show pin2");

    // R9 software reset
    wr(4'd15, 32'h1);
    idle(2);
    rd(4'd15, 32'h1, "R9 reset bit readback");
    rd(4'd1, 32'h0, "R9 status held");
    chk("R9 irq", {31'd0, irq}, 32'd0);
    chk("R9 pin_out", {20'd0, pin_out}, 32'd0);
    chk("R9 pin_oe", {20'd0, pin_oe}, 32'd0);
    wr(4'd0, 32'hFFF);
    wr(4'd15, 32'h0);
    idle(1);
    rd(4'd0, 32'h0, "R9 write during reset ignored");
    rd(4'd4, 32'hFFF, "R9 mask default");
    rd(4'd9, 32'h0, "R9 mode default");
    rd(4'd15, 32'h0, "R9 released");

    idle(3);
    chk("scoreboard drained", sb_q.size(), 32'd0);
    done = 1'b1;
    finish_run();
  end
endmodule